// File: doc/BRIEF.md
# Flag-Guided Scrub Command Sequencer

This block walks a memory array codeword by codeword and issues the DRAM command stream needed to scrub it. Commands leave one at a time on a valid/ready handshake as an operation code with a row and a column address. After each read the sequencer waits for the read-completion strobe. It then decides what to do next from the per-byte error flags and a data-mismatch indication that arrive with that strobe.

Two behaviours are available, chosen when a pass starts. The conventional behaviour writes every codeword back. The guided behaviour skips the write for codewords that read clean. A flagged codeword is written back and read again. If the second read is clean, the event counts as transient. If the second read still shows trouble, the event counts as permanent and the whole page is moved to a spare row: every column of the old row is read, the spare row is opened, every column is written into it, and both rows are closed. Per-pass transient and permanent counts are presented on output ports.

Top module: `flag_scrub_seq`

## Requirements
- R1: After reset the block is idle. cmd_valid, busy and done are 0, and both event counts are 0.
- R2: A pass begins only on a start pulse while busy is 0. A start pulse during a pass has no effect on the command stream and does not create an extra done pulse.
- R3: The command codes are ACT=0, RD=1, WR=2 and PRE=3. In conventional mode every codeword gets ACT, RD, WR, PRE whatever the read reports, and both event counts stay 0.
- R4: In guided mode, a codeword whose first read returns all flags 0 gets ACT, RD, PRE with no write.
- R5: In guided mode, a first read with any flag set leads to WR then RD on the same codeword. If that re-read returns flags 0 and mismatch 0, a PRE follows and the transient count rises by 1.
- R6: If the re-read returns any flag set or mismatch 1, the block issues MIG_LEN reads on the current row (columns 0 up to MIG_LEN-1), an ACT to the spare row, MIG_LEN writes to the spare row (columns 0 up to MIG_LEN-1), a PRE to the current row and a PRE to the spare row, in that order. The permanent count rises by 1.
- R7: The spare row is sampled when the permanent decision is made. Later changes on spare_row do not alter the migration that is in progress.
- R8: Codewords are visited with the column running from 0 to COLS-1 inside a row, then the next row, for rows 0 to ROWS-1. ACT and PRE carry column 0. RD and WR on a scrubbed codeword carry its own column.
- R9: One cycle after the final PRE of the last row is accepted, done pulses for exactly one cycle while busy is 0. The counts hold their values until the next start, which clears them.
- R10: A command is held stable while cmd_valid is 1 and cmd_ready is 0. Every decision is taken from the flag and mismatch values present in the cycle rd_done is 1, and never from values presented while rd_done is 0.
- R11: The mode is sampled at start. Changing mode_guided during a pass has no effect on that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a pass |
| mode_guided | input | 1 | 1 = guided scrubbing, 0 = write back every codeword |
| spare_row | input | ROW_W | Destination row for a page migration |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted when high together with cmd_valid |
| cmd_op | output | 2 | Command code (ACT=0, RD=1, WR=2, PRE=3) |
| cmd_row | output | ROW_W | Row address |
| cmd_col | output | COL_W | Column (codeword) address |
| rd_done | input | 1 | Read data and its status are available |
| rd_err_flags | input | FLAG_W | Per-byte error flags of the completed read |
| rd_mismatch | input | 1 | Re-read data differs from the written data |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at end of pass |
| transient_cnt | output | CNT_W | Transient events in the current or last pass |
| permanent_cnt | output | CNT_W | Permanent events in the current or last pass |

## Verification
Two functions can meet in the same cycle: a start pulse can land while a pass is running, and the spare-row input can change while a migration it started is still being issued. The bench raises start and flips the mode in the middle of a guided pass. It requires the full accepted command stream to equal the guided expectation, with exactly one done. During a migration it drives spare_row to a junk value and requires every spare-row command to keep the value that was present at the decision. The flag and mismatch inputs carry junk whenever rd_done is low, so any decision taken at the wrong moment shows up in the command stream.

// File: rtl/flag_scrub_seq.sv
module flag_scrub_seq #(
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 6,
  parameter int MIG_LEN = 64,
  parameter int FLAG_W  = 8,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_guided,
  input  logic [ROW_W-1:0] spare_row,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  input  logic             rd_done,
  input  logic [FLAG_W-1:0] rd_err_flags,
  input  logic             rd_mismatch,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] transient_cnt,
  output logic [CNT_W-1:0] permanent_cnt
);
  localparam int MIG_W = (MIG_LEN > 1) ? $clog2(MIG_LEN) : 1;
  localparam logic [1:0] OP_ACT = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_PRE = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_ACT, S_RD, S_WAIT, S_WR, S_MRD, S_MACT, S_MWR, S_PRE, S_PRE2
  } st_t;

  st_t              st;
  logic [ROW_W-1:0] row, spare_q;
  logic [COL_W-1:0] col;
  logic [MIG_W-1:0] mcnt;
  logic             guided_q, reread, migr;

  wire fire     = cmd_valid & cmd_ready;
  wire last_col = col == COL_W'(COLS - 1);
  wire last_row = row == ROW_W'(ROWS - 1);
  wire last_m   = mcnt == MIG_W'(MIG_LEN - 1);
  wire err1     = |rd_err_flags;
  wire persist  = (|rd_err_flags) | rd_mismatch;
  wire advance  = fire & ((st == S_PRE & ~migr) | st == S_PRE2);

  assign busy      = st != S_IDLE;
  assign cmd_valid = st != S_IDLE && st != S_WAIT;
  assign cmd_row   = (st == S_MACT || st == S_MWR || st == S_PRE2) ? spare_q : row;
  assign cmd_col   = (st == S_MRD || st == S_MWR) ? COL_W'(mcnt) :
                     (st == S_RD || st == S_WR) ? col : '0;

  always_comb begin
    case (st)
      S_ACT, S_MACT: cmd_op = OP_ACT;
      S_WR, S_MWR:   cmd_op = OP_WR;
      S_PRE, S_PRE2: cmd_op = OP_PRE;
      default:       cmd_op = OP_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      row <= '0;
      col <= '0;
      mcnt <= '0;
      spare_q <= '0;
      guided_q <= 1'b0;
      reread <= 1'b0;
      migr <= 1'b0;
      done <= 1'b0;
      transient_cnt <= '0;
      permanent_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          row <= '0;
          col <= '0;
          transient_cnt <= '0;
          permanent_cnt <= '0;
          guided_q <= mode_guided;
          st <= S_ACT;
        end
        S_ACT: if (fire) st <= S_RD;
        S_RD:  if (fire) st <= S_WAIT;
        S_WAIT: if (rd_done) begin
          if (reread) begin
            reread <= 1'b0;
            if (persist) begin
              permanent_cnt <= permanent_cnt + 1'b1;
              spare_q <= spare_row;
              migr <= 1'b1;
              mcnt <= '0;
              st <= S_MRD;
            end else begin
              transient_cnt <= transient_cnt + 1'b1;
              st <= S_PRE;
            end
          end else if (!guided_q || err1) st <= S_WR;
          else st <= S_PRE;
        end
        S_WR: if (fire) begin
          if (guided_q) begin
            reread <= 1'b1;
            st <= S_RD;
          end else st <= S_PRE;
        end
        S_MRD: if (fire) begin
          mcnt <= last_m ? '0 : mcnt + 1'b1;
          if (last_m) st <= S_MACT;
        end
        S_MACT: if (fire) st <= S_MWR;
        S_MWR: if (fire) begin
          mcnt <= last_m ? '0 : mcnt + 1'b1;
          if (last_m) st <= S_PRE;
        end
        S_PRE: if (fire && migr) st <= S_PRE2;
        default: ;
      endcase
      if (advance) begin
        migr <= 1'b0;
        col <= last_col ? '0 : col + 1'b1;
        if (last_col && !last_row) row <= row + 1'b1;
        if (last_col && last_row) begin
          done <= 1'b1;
          st <= S_IDLE;
        end else st <= S_ACT;
      end
    end
  end
endmodule

// File: rtl/scrub_seq_chk.sv
module scrub_seq_chk #(
  parameter int ROW_W = 4,
  parameter int COL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [ROW_W-1:0] cmd_row,
  input logic [COL_W-1:0] cmd_col,
  input logic             guided
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  assert_start_needed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_conv_wr_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!guided && cmd_valid && cmd_ready && cmd_op == 2'd2) |=> (cmd_valid && cmd_op == 2'd3));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_row) && $stable(cmd_col)));
endmodule

bind flag_scrub_seq scrub_seq_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_row(cmd_row), .cmd_col(cmd_col), .guided(guided_q)
);

// File: tb/sim_flag_scrub_seq.sv
`timescale 1ns/1ps
module sim_flag_scrub_seq;
  localparam int ROWS = 4, COLS = 4, MIG = 64;
  localparam logic [3:0] SP_GOOD = 4'hA, SP_JUNK = 4'hF;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_guided = 1'b0;
  logic [3:0] spare_row = SP_GOOD;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [3:0] cmd_row;
  logic [5:0] cmd_col;
  logic rd_done = 1'b0, rd_mismatch = 1'b1;
  logic [7:0] rd_err_flags = 8'hFF;
  logic busy, done;
  logic [7:0] transient_cnt, permanent_cnt;

  flag_scrub_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_guided(mode_guided),
    .spare_row(spare_row), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col), .rd_done(rd_done),
    .rd_err_flags(rd_err_flags), .rd_mismatch(rd_mismatch), .busy(busy),
    .done(done), .transient_cnt(transient_cnt), .permanent_cnt(permanent_cnt)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ready_mode = 0, rd_lat = 0;
  int kind [0:ROWS*COLS-1];
  logic [11:0] log_q [0:4095];
  logic [11:0] exp_q [0:4095];
  int log_n = 0, exp_n = 0, exp_tr = 0, exp_pm = 0;
  int done_cnt = 0, done_busy_err = 0, hold_err = 0;
  bit after_wr = 0, pend = 0, fire_next = 0, pv = 0, pr = 0;
  int pend_cnt = 0;
  logic [7:0] pend_f = 8'h0, nf = 8'h0;
  logic pend_m = 1'b0, nm = 1'b0;
  logic [11:0] pcmd = '0;

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stimulus-side drivers, just after the rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    cmd_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    rd_done = fire_next;
    rd_err_flags = fire_next ? nf : 8'hFF;
    rd_mismatch = fire_next ? nm : 1'b1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_up();
    end
  end

  // monitor and memory responder, away from the active edge
  always @(negedge clk) begin
    logic [11:0] cur;
    cur = {cmd_op, cmd_row, cmd_col};
    fire_next = 0;
    if (pend) begin
      if (pend_cnt == 0) begin
        fire_next = 1; nf = pend_f; nm = pend_m; pend = 0;
      end else pend_cnt--;
    end
    if (rst_n) begin
      if (pv && !pr && (!cmd_valid || cur != pcmd)) hold_err++;
      if (done) begin
        done_cnt++;
        if (busy) done_busy_err++;
      end
      if (cmd_valid && cmd_ready) begin
        log_q[log_n] = cur;
        log_n++;
        if (cmd_op == 2'd1) begin
          int k;
          logic [7:0] f;
          logic m;
          k = (int'(cmd_col) < COLS) ? kind[int'(cmd_row) * COLS + int'(cmd_col)] : 0;
          f = 8'h0; m = 1'b0;
          if (!after_wr) f = (k != 0) ? 8'h04 : 8'h00;
          else if (k == 2) f = 8'h10;
          else if (k == 3) m = 1'b1;
          after_wr = 0;
          if (rd_lat == 0) begin
            fire_next = 1; nf = f; nm = m;
          end else begin
            pend = 1; pend_cnt = rd_lat - 1; pend_f = f; pend_m = m;
          end
          if (int'(cmd_col) == COLS && after_wr == 0 && busy) spare_row = SP_JUNK;
        end else if (cmd_op == 2'd2) after_wr = 1;
        else if (cmd_op == 2'd0) after_wr = 0;
        else if (cmd_op == 2'd3 && cmd_row == SP_GOOD) spare_row = SP_GOOD;
      end
    end
    pv = cmd_valid; pr = cmd_ready; pcmd = cur;
  end

  function automatic logic [11:0] pk(input int op, input int r, input int c);
    return {op[1:0], r[3:0], c[5:0]};
  endfunction

  task automatic push(input int op, input int r, input int c);
    exp_q[exp_n] = pk(op, r, c);
    exp_n++;
  endtask

  task automatic build_exp(input bit g);
    exp_n = 0; exp_tr = 0; exp_pm = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int k;
        k = kind[r * COLS + c];
        push(0, r, 0);
        push(1, r, c);
        if (!g) begin
          push(2, r, c); push(3, r, 0);
        end else if (k == 0) push(3, r, 0);
        else begin
          push(2, r, c); push(1, r, c);
          if (k == 1) begin
            exp_tr++; push(3, r, 0);
          end else begin
            exp_pm++;
            for (int m = 0; m < MIG; m++) push(1, r, m);
            push(0, SP_GOOD, 0);
            for (int m = 0; m < MIG; m++) push(2, SP_GOOD, m);
            push(3, r, 0);
            push(3, SP_GOOD, 0);
          end
        end
      end
  endtask

  task automatic run_pass(input bit g, input string req, input bit poke);
    int d0, diff;
    build_exp(g);
    log_n = 0; hold_err = 0; done_busy_err = 0;
    d0 = done_cnt;
    @(posedge clk); #2;
    mode_guided = g; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk);
    check(transient_cnt == 0 && permanent_cnt == 0, "R9 counts cleared at start",
          int'(transient_cnt) + int'(permanent_cnt), 0);
    if (poke) begin
      repeat (30) @(posedge clk);
      #2; start = 1'b1; mode_guided = ~g;
      @(posedge clk); #2; start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (12) @(negedge clk);
    diff = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (diff < 0 && log_q[i] != exp_q[i]) diff = i;
    if (diff < 0 && log_n != exp_n) diff = (log_n < exp_n) ? log_n : exp_n;
    if (diff >= 0)
      check(0, req, (diff < log_n) ? int'(log_q[diff]) : -1, (diff < exp_n) ? int'(exp_q[diff]) : -1);
    else check(1, req, 0, 0);
    check(log_n == exp_n, {req, " stream length"}, log_n, exp_n);
    check(done_cnt == d0 + 1, "R9 single done per pass", done_cnt - d0, 1);
    check(done_busy_err == 0 && !busy, "R9 idle with done", done_busy_err, 0);
    check(hold_err == 0, "R10 command hold under stall", hold_err, 0);
    check(transient_cnt == exp_tr, "R5 transient count", transient_cnt, exp_tr);
    check(permanent_cnt == exp_pm, "R6 permanent count", permanent_cnt, exp_pm);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!cmd_valid, "R1 cmd_valid", cmd_valid, 0);
    check(!busy && !done, "R1 busy/done", int'(busy) + int'(done), 0);
    check(transient_cnt == 0 && permanent_cnt == 0, "R1 counts",
          int'(transient_cnt) + int'(permanent_cnt), 0);
  endtask

  task automatic t_conventional();
    foreach (kind[i]) kind[i] = (i % 3 == 0) ? 2 : 0;
    ready_mode = 0; rd_lat = 2;
    run_pass(1'b0, "R3 R8 conventional stream", 1'b0);
  endtask

  task automatic t_guided_clean();
    foreach (kind[i]) kind[i] = 0;
    ready_mode = 1; rd_lat = 0;
    run_pass(1'b1, "R4 clean guided stream", 1'b0);
  endtask

  task automatic t_guided_faults();
    foreach (kind[i]) kind[i] = 0;
    kind[1] = 1; kind[6] = 2; kind[8] = 1; kind[15] = 3;
    ready_mode = 1; rd_lat = 3;
    run_pass(1'b1, "R5 R6 R7 R10 faulty guided stream", 1'b0);
    repeat (5) @(negedge clk);
    check(transient_cnt == 2 && permanent_cnt == 2, "R9 counts hold after pass",
          int'(transient_cnt) * 16 + int'(permanent_cnt), 2 * 16 + 2);
  endtask

  task automatic t_midpass();
    foreach (kind[i]) kind[i] = 0;
    kind[5] = 1; kind[10] = 1;
    ready_mode = 0; rd_lat = 1;
    run_pass(1'b1, "R2 R11 start and mode ignored mid-pass", 1'b1);
  endtask

  initial begin
    foreach (kind[i]) kind[i] = 0;
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    t_reset();
    t_conventional();
    t_guided_clean();
    t_guided_faults();
    t_midpass();
    finish_up();
  end
endmodule